// File: doc/BRIEF.md
# Dual-Output Interrupt Mask Controller

This block gathers a vector of level-sensitive interrupt sources and drives two processor request lines from it: a normal request and a fast request. Both lines look at the same raw source vector, and each has its own enable mask. Software changes a mask only through a pair of registers: one that sets the mask bits written as 1 and one that clears them. This lets independent software agents change their own bits without a read-modify-write sequence.

Source bit 0 can also be raised by software. A software flag, set and cleared through its own register pair, is ORed with hardware source 0 before masking. Access is through a plain word-addressed register port: a word offset, a write strobe, write data and registered read data. Both request outputs are registered, so they follow a source or mask change one clock later.

Top module: `intmask_ctrl`

## Requirements
- R1: After a synchronous reset, both enable masks and the software flag are 0, and irq_o, fiq_o and reg_rdata_o are 0.
- R2: A write to offset 2 ORs the write data into the normal enable mask. A read of offset 2 returns that mask.
- R3: A write to offset 3 clears every normal-mask bit whose write-data bit is 1. Other mask bits keep their value.
- R4: Offsets 10 and 11 do for the fast enable mask what offsets 2 and 3 do for the normal mask. A read of offset 10 returns the fast mask.
- R5: A write to offset 4 with data bit 0 set raises the software flag. A write to offset 5 with data bit 0 set lowers it. Write-data bits other than bit 0 have no effect. A read of offset 4 returns raw bit 0 in bit 0 and zeros in every other bit.
- R6: Raw bit 0 is src_i[0] ORed with the software flag. Every other raw bit equals its src_i bit. Reads of offset 1 and offset 9 both return the raw vector.
- R7: A read of offset 0 returns the raw vector ANDed with the normal mask. A read of offset 8 returns the raw vector ANDed with the fast mask.
- R8: irq_o is the OR of (raw AND normal mask) and fiq_o is the OR of (raw AND fast mask), both taken at the previous rising clock edge. So an output changes on the edge after the mask or source change.
- R9: Writes to offsets 0, 1, 8 and 9, and to the unused offsets 6, 7 and 12 to 15, change no state. Reads of offsets 3, 5, 11 and of the unused offsets return 0.
- R10: reg_rdata_o shows the register addressed at the previous rising edge, with the value that register held just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_ofs_i | input | 4 | Word offset of the register accessed |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| src_i | input | 32 | Level-sensitive interrupt sources |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The bench walks every source bit through both masks. For each bit, the normal mask enables only that bit and the fast mask enables every bit except it, so a request line wired to the wrong mask, or a status read that skips the AND, shows up at once. Mixed set and clear patterns catch a clear register that writes the mask instead of clearing bits, and a set register that overwrites the mask instead of ORing into it. The software flag is driven with data that has bit 0 clear but other bits set, to catch a decode that does not isolate bit 0. The flag is also tested with hardware source 0 active, to catch a design that replaces source 0 instead of ORing into it. Outputs are sampled both on the edge right after a change and on the edge after that, which shows up a request path that is combinational or two stages deep.

// File: rtl/intmask_pkg.sv
package intmask_pkg;
  localparam int OFS_W       = 4;
  localparam int NUM_CHAN    = 2;
  localparam int CHAN_STRIDE = 8;

  // word offsets; channel c adds c*CHAN_STRIDE to the channel-local ones
  localparam logic [OFS_W-1:0] OFS_PEND  = 4'd0;
  localparam logic [OFS_W-1:0] OFS_RAW   = 4'd1;
  localparam logic [OFS_W-1:0] OFS_ENSET = 4'd2;
  localparam logic [OFS_W-1:0] OFS_ENCLR = 4'd3;
  localparam logic [OFS_W-1:0] OFS_SWSET = 4'd4;
  localparam logic [OFS_W-1:0] OFS_SWCLR = 4'd5;

  function automatic logic [OFS_W-1:0] chan_ofs(input int chan, input logic [OFS_W-1:0] local_ofs);
    return local_ofs + OFS_W'(chan * CHAN_STRIDE);
  endfunction
endpackage

// File: rtl/intmask_mask_reg.sv
module intmask_mask_reg
  import intmask_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter logic [OFS_W-1:0] SET_OFS = 4'd2,
  parameter logic [OFS_W-1:0] CLR_OFS = 4'd3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [WIDTH-1:0] wr_bits,
  output logic [WIDTH-1:0] mask_o
);
  logic set_hit, clr_hit;
  assign set_hit = wr_en && (wr_ofs == SET_OFS);
  assign clr_hit = wr_en && (wr_ofs == CLR_OFS);

  always_ff @(posedge clk) begin
    if (rst)          mask_o <= '0;
    else if (set_hit) mask_o <= mask_o | wr_bits;
    else if (clr_hit) mask_o <= mask_o & ~wr_bits;
  end

  // R2/R4: bits written to the set offset are 1 afterwards, others keep value
  p_set_or_r2: assert property (@(posedge clk) disable iff (rst)
    set_hit |=> ((mask_o & $past(wr_bits)) == $past(wr_bits)) &&
                ((mask_o & ~$past(wr_bits)) == ($past(mask_o) & ~$past(wr_bits))));
  // R3/R4: bits written to the clear offset are 0 afterwards, others keep value
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> ((mask_o & $past(wr_bits)) == '0) &&
                ((mask_o & ~$past(wr_bits)) == ($past(mask_o) & ~$past(wr_bits))));
  // R9: no write to this mask's offsets leaves it unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(set_hit || clr_hit) |=> $stable(mask_o));
endmodule

// File: rtl/intmask_soft_src.sv
module intmask_soft_src
  import intmask_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic             wr_bit0,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] raw_o
);
  logic swi_q;
  logic sw_set, sw_clr;
  assign sw_set = wr_en && (wr_ofs == OFS_SWSET) && wr_bit0;
  assign sw_clr = wr_en && (wr_ofs == OFS_SWCLR) && wr_bit0;

  always_ff @(posedge clk) begin
    if (rst)         swi_q <= 1'b0;
    else if (sw_set) swi_q <= 1'b1;
    else if (sw_clr) swi_q <= 1'b0;
  end

  assign raw_o = src_i | WIDTH'(swi_q);

  // R5: set and clear writes take effect on the next cycle
  p_swi_set_r5: assert property (@(posedge clk) disable iff (rst) sw_set |=> swi_q);
  p_swi_clr_r5: assert property (@(posedge clk) disable iff (rst) sw_clr |=> !swi_q);
  // R5: without a qualifying write the flag holds
  p_swi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(sw_set || sw_clr) |=> $stable(swi_q));
  // R6: the flag forces raw bit 0
  p_raw0_r6: assert property (@(posedge clk) disable iff (rst) swi_q |-> raw_o[0]);
endmodule

// File: rtl/intmask_out_stage.sv
module intmask_out_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] pend_o,
  output logic             req_o
);
  assign pend_o = raw_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) req_o <= 1'b0;
    else     req_o <= |pend_o;
  end

  // R8: an all-zero mask at the last edge means no request now
  p_mask_gate_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_i) == '0) |-> !req_o);
  // R8: no raw source at the last edge means no request now
  p_raw_gate_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(raw_i) == '0) |-> !req_o);
endmodule

// File: rtl/intmask_read_mux.sv
module intmask_read_mux
  import intmask_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [OFS_W-1:0]              rd_ofs,
  input  logic [WIDTH-1:0]              raw_i,
  input  logic [NUM_CHAN-1:0][WIDTH-1:0] mask_i,
  input  logic [NUM_CHAN-1:0][WIDTH-1:0] pend_i,
  output logic [DATA_W-1:0]             rdata_o
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (rd_ofs == chan_ofs(c, OFS_PEND))  rd_next = DATA_W'(pend_i[c]);
      if (rd_ofs == chan_ofs(c, OFS_RAW))   rd_next = DATA_W'(raw_i);
      if (rd_ofs == chan_ofs(c, OFS_ENSET)) rd_next = DATA_W'(mask_i[c]);
    end
    if (rd_ofs == OFS_SWSET) rd_next = DATA_W'(raw_i[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

  // R9: clear-only offsets read back as zero
  p_clr_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_ofs) == OFS_ENCLR || $past(rd_ofs) == OFS_SWCLR ||
     $past(rd_ofs) == chan_ofs(1, OFS_ENCLR)) |-> (rdata_o == '0));
  // R5: the software-source read has only bit 0 live
  p_swi_read_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_ofs) == OFS_SWSET) |-> (rdata_o[DATA_W-1:1] == '0));
  // R10: raw reads show the source vector of the previous edge
  p_raw_read_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_ofs) == OFS_RAW) |-> (rdata_o == DATA_W'($past(raw_i))));
endmodule

// File: rtl/intmask_ctrl.sv
module intmask_ctrl
  import intmask_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  reg_ofs_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [NUM_SRC-1:0]                raw;
  logic [NUM_CHAN-1:0][NUM_SRC-1:0]  mask_q;
  logic [NUM_CHAN-1:0][NUM_SRC-1:0]  pend;
  logic [NUM_CHAN-1:0]               req;

  intmask_soft_src #(.WIDTH(NUM_SRC)) u_soft (
    .clk(clk), .rst(rst), .wr_en(reg_wr_i), .wr_ofs(reg_ofs_i),
    .wr_bit0(reg_wdata_i[0]), .src_i(src_i), .raw_o(raw)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    intmask_mask_reg #(
      .WIDTH(NUM_SRC),
      .SET_OFS(chan_ofs(c, OFS_ENSET)),
      .CLR_OFS(chan_ofs(c, OFS_ENCLR))
    ) u_mask (
      .clk(clk), .rst(rst), .wr_en(reg_wr_i), .wr_ofs(reg_ofs_i),
      .wr_bits(reg_wdata_i[NUM_SRC-1:0]), .mask_o(mask_q[c])
    );
    intmask_out_stage #(.WIDTH(NUM_SRC)) u_out (
      .clk(clk), .rst(rst), .raw_i(raw), .mask_i(mask_q[c]),
      .pend_o(pend[c]), .req_o(req[c])
    );
  end

  intmask_read_mux #(.WIDTH(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_ofs(reg_ofs_i), .raw_i(raw),
    .mask_i(mask_q), .pend_i(pend), .rdata_o(reg_rdata_o)
  );

  assign irq_o = req[0];
  assign fiq_o = req[1];

  // R9: writes to status and raw offsets leave every mask unchanged
  p_stat_wr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && (reg_ofs_i == OFS_PEND || reg_ofs_i == OFS_RAW ||
                  reg_ofs_i == chan_ofs(1, OFS_PEND) || reg_ofs_i == chan_ofs(1, OFS_RAW)))
    |=> $stable(mask_q));
endmodule

// File: tb/intmask_ctrl_tb.sv
module intmask_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst;
  logic [3:0]   ofs;
  logic         wr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic [W-1:0] src;
  logic irq, fiq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W-1:0] m_irq, m_fiq;
  logic         m_swi;

  always #(CLK_PERIOD/2) clk = ~clk;

  intmask_ctrl #(.NUM_SRC(W), .DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .reg_ofs_i(ofs), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .src_i(src), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [W-1:0] m_raw();
    return src | W'(m_swi);
  endfunction

  function automatic logic [W-1:0] m_read(input logic [3:0] o);
    case (o)
      4'd0:  return m_raw() & m_irq;
      4'd1:  return m_raw();
      4'd2:  return m_irq;
      4'd4:  return W'(m_raw()[0]);
      4'd8:  return m_raw() & m_fiq;
      4'd9:  return m_raw();
      4'd10: return m_fiq;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write one register; model updated to match
  task automatic wr_reg(input logic [3:0] o, input logic [W-1:0] d);
    ofs = o; wr = 1'b1; wdata = d;
    @(posedge clk);
    case (o)
      4'd2:  m_irq = m_irq | d;
      4'd3:  m_irq = m_irq & ~d;
      4'd10: m_fiq = m_fiq | d;
      4'd11: m_fiq = m_fiq & ~d;
      4'd4:  if (d[0]) m_swi = 1'b1;
      4'd5:  if (d[0]) m_swi = 1'b0;
      default: ;
    endcase
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] o);
    logic [W-1:0] exp;
    ofs = o; wr = 1'b0;
    exp = m_read(o);
    @(negedge clk);
    check(req, rdata, exp);
  endtask

  // outputs one full cycle after stimulus settled
  task automatic out_chk(input string req);
    @(negedge clk);
    check({req, " irq"}, W'(irq), W'(|(m_raw() & m_irq)));
    check({req, " fiq"}, W'(fiq), W'(|(m_raw() & m_fiq)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic prev_irq;
    rst = 1'b1; ofs = '0; wr = 1'b0; wdata = '0; src = '0;
    m_irq = '0; m_fiq = '0; m_swi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 irq", W'(irq), '0);
    check("R1 fiq", W'(fiq), '0);
    check("R1 rdata", rdata, '0);
    rst = 1'b0;
    rd_chk("R1 irq mask", 4'd2);
    rd_chk("R1 fiq mask", 4'd10);
    rd_chk("R1 swi", 4'd4);

    // R2/R3/R4: set ORs, clear removes only written bits
    wr_reg(4'd2, 32'h0000_00F0); wr_reg(4'd2, 32'h0F00_0001);
    rd_chk("R2 set or", 4'd2);
    wr_reg(4'd3, 32'h0000_0030);
    rd_chk("R3 clr bits", 4'd2);
    wr_reg(4'd10, 32'hA5A5_0000); wr_reg(4'd10, 32'h0000_5A5A);
    rd_chk("R4 fiq set", 4'd10);
    wr_reg(4'd11, 32'hFF00_00FF);
    rd_chk("R4 fiq clr", 4'd10);
    rd_chk("R2 irq mask after fiq writes", 4'd2);

    // R9: writes to status, raw and unused offsets ignored
    wr_reg(4'd0, '1); wr_reg(4'd1, '1); wr_reg(4'd8, '1); wr_reg(4'd9, '1);
    wr_reg(4'd6, '1); wr_reg(4'd13, '1);
    rd_chk("R9 irq mask kept", 4'd2);
    rd_chk("R9 fiq mask kept", 4'd10);
    rd_chk("R9 swi kept", 4'd4);
    rd_chk("R9 read 3", 4'd3);
    rd_chk("R9 read 5", 4'd5);
    rd_chk("R9 read 11", 4'd11);
    rd_chk("R9 read 15", 4'd15);

    // R6/R7 with a mixed source pattern
    src = 32'h1234_5678;
    rd_chk("R6 raw", 4'd1);
    rd_chk("R6 fiq raw", 4'd9);
    rd_chk("R7 irq pend", 4'd0);
    rd_chk("R7 fiq pend", 4'd8);
    out_chk("R8 mixed");

    // R5: software flag; non-bit-0 data has no effect
    wr_reg(4'd3, '1); wr_reg(4'd11, '1); src = '0;
    wr_reg(4'd4, 32'hFFFF_FFFE);
    rd_chk("R5 swi ignored bits", 4'd4);
    wr_reg(4'd4, 32'h0000_0001);
    rd_chk("R5 swi set", 4'd4);
    rd_chk("R6 swi in raw", 4'd1);
    wr_reg(4'd2, 32'h1);
    out_chk("R8 swi irq");
    src = 32'h1;
    wr_reg(4'd5, 32'h1);
    rd_chk("R6 hw src0 kept", 4'd4);
    src = '0;
    wr_reg(4'd5, 32'hFFFF_FFFE);
    rd_chk("R5 swi clr ignored bits", 4'd4);
    wr_reg(4'd5, 32'h1);
    rd_chk("R5 swi clr", 4'd4);
    wr_reg(4'd3, '1);

    // R8/R7 sweep: every source bit, irq mask one-hot, fiq mask inverse
    for (int i = 0; i < W; i++) begin
      wr_reg(4'd3, '1); wr_reg(4'd11, '1);
      wr_reg(4'd2, W'(1) << i);
      wr_reg(4'd10, ~(W'(1) << i));
      src = W'(1) << i;
      rd_chk("R7 sweep irq pend", 4'd0);
      rd_chk("R7 sweep fiq pend", 4'd8);
      check("R8 sweep irq", W'(irq), W'(1));
      check("R8 sweep fiq", W'(fiq), W'(0));
      src = ~(W'(1) << i);
      out_chk("R8 sweep inverse");
    end

    // R8: one-cycle latency of a mask change
    src = 32'h8000_0000;
    wr_reg(4'd3, '1); wr_reg(4'd11, '1);
    @(negedge clk);
    prev_irq = irq;
    ofs = 4'd2; wr = 1'b1; wdata = 32'h8000_0000;
    @(posedge clk); m_irq = m_irq | 32'h8000_0000;
    @(negedge clk); wr = 1'b0;
    check("R8 not yet", W'(irq), W'(prev_irq));
    @(negedge clk);
    check("R8 after one edge", W'(irq), W'(1));

    // R10: read shows pre-write value in the write cycle
    ofs = 4'd2; wr = 1'b1; wdata = 32'h0000_0001;
    @(posedge clk);
    @(negedge clk); wr = 1'b0;
    check("R10 read before write", rdata, m_irq);
    m_irq = m_irq | 32'h1;
    rd_chk("R10 read after write", 4'd2);

    // R1: reset in mid-operation
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    m_irq = '0; m_fiq = '0; m_swi = 1'b0;
    check("R1 rerst irq", W'(irq), '0);
    rd_chk("R1 rerst mask", 4'd2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule